// File: doc/BRIEF.md
# Serial ADC Host Reader

This block is the host side of a three-wire link to a two-channel serial analog-to-digital converter. A request carries a 2-bit channel code. The reader pulls chip select low and derives a 50% duty serial clock from the system clock. It shifts out a start bit and the channel code, then lets go of the data line so that a single shared pin can carry both directions. It collects the 8-bit conversion word, which arrives most significant bit first, and then the copy the converter sends straight after it, least significant bit first.

The echo is rebuilt into a word and compared with the first copy. The result is then reported with a one-cycle valid strobe and a mismatch flag. After every transfer chip select stays high for at least one serial clock period before a new request can be taken. Requests that arrive while the reader is busy are dropped.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, chip select is high (`ser_cs_n`=1), the serial clock is low, the data driver is off, and `busy` and `rslt_valid` are 0.
- R2: A request seen in idle is accepted on that clock edge, which drives `ser_cs_n` low and `busy` high. The first serial clock rise comes DIV_HALF system cycles later. The serial clock then stays high for DIV_HALF cycles and low for DIV_HALF cycles.
- R3: The converter sees a 1 on the first rising serial clock edge. On the second and third rising edges it sees `chan[1]` and then `chan[0]`.
- R4: The reader turns its data driver off on the third falling serial clock edge, one falling edge before the converter starts driving. The two never drive the line at the same time.
- R5: The line is sampled on rising edges 5 to 12. `rslt_data` is those 8 bits, the first one placed in bit 7.
- R6: Rising edges 13 to 19 carry result bits 1 to 7 in that order. `rslt_err` is 1 when the word rebuilt from these bits and bit 0 of the first copy differs from `rslt_data`, and 0 when the two match.
- R7: `rslt_valid` is high for exactly one cycle, 38·DIV_HALF system cycles after the accepting edge. `ser_cs_n` rises on that same edge, after exactly 19 rising serial clock edges.
- R8: `busy` stays high for 2·DIV_HALF cycles after chip select rises. A request held high is accepted again on the next edge, so chip select is high for 2·DIV_HALF+1 cycles between transfers.
- R9: A request made while `busy` is high starts nothing and does not change the channel of the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start one read when idle |
| chan | input | 2 | Channel/mode code sent after the start bit |
| busy | output | 1 | Transfer or chip-select recovery in progress |
| rslt_valid | output | 1 | One-cycle strobe for a finished read |
| rslt_data | output | 8 | Conversion word, MSB-first copy |
| rslt_err | output | 1 | The two copies of the word differ |
| ser_cs_n | output | 1 | Converter chip select, active low |
| ser_clk | output | 1 | Serial clock |
| ser_dq_o | output | 1 | Data value driven toward the converter |
| ser_dq_oe | output | 1 | Enable for the host data driver |
| ser_dq_i | input | 1 | Data line as seen at the pin |

## Verification
Every result is tied to the system edge that accepts the request. In the bench that edge is count 1 of a per-cycle counter that advances at each rising clock and is read at the next falling clock. By that count, the first serial clock rise is due at DIV_HALF+1 and the first fall at 2·DIV_HALF+1. The data driver must go off exactly when the third fall is observed, the valid strobe must show at 38·DIV_HALF+1, and `busy` must drop at 40·DIV_HALF+1. The bench compares each observed count with these figures. The behavioural converter model records the three command bits and the number of rising edges it saw, and the bench checks those when chip select rises.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_XFER = 2'd1,
      RD_GAP  = 2'd2
   } rd_state_t;

   // rising serial edge that carries the first MSB-first result bit
   function automatic int first_data_rise(input int addr_bits);
      return addr_bits + 3;
   endfunction

   function automatic int last_msb_rise(input int addr_bits, input int res_bits);
      return first_data_rise(addr_bits) + res_bits - 1;
   endfunction

   function automatic int last_rise(input int addr_bits, input int res_bits, input bit echo);
      return echo ? last_msb_rise(addr_bits, res_bits) + res_bits - 1
                  : last_msb_rise(addr_bits, res_bits);
   endfunction

endpackage

// File: rtl/adc_rd_clkgen.sv
module adc_rd_clkgen #(
   parameter int DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic sclk,
   output logic rise_tk,
   output logic fall_tk
);
   localparam int CW = $clog2(DIV_HALF + 1);

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap    = en && (cnt == CW'(DIV_HALF - 1));
   assign rise_tk = wrap && !sclk;
   assign fall_tk = wrap &&  sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (!en) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (wrap) begin
         cnt  <= '0;
         sclk <= ~sclk;
      end else begin
         cnt  <= cnt + CW'(1);
      end
   end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
   import adc_rd_pkg::*;
#(
   parameter int DIV_HALF  = 4,
   parameter int ADDR_BITS = 2,
   parameter int RES_BITS  = 8,
   parameter bit ECHO      = 1'b1,
   parameter int HW        = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic [ADDR_BITS-1:0] chan,
   input  logic                 tick,
   output logic                 busy,
   output logic                 sclk_en,
   output logic                 cs_n,
   output logic                 dq_o,
   output logic                 dq_oe,
   output logic [HW-1:0]        hnext,
   output logic                 done
);
   localparam int END_HALF     = 2 * last_rise(ADDR_BITS, RES_BITS, ECHO);
   localparam int RELEASE_HALF = 2 * (ADDR_BITS + 1);
   localparam int GAP_LEN      = 2 * DIV_HALF;
   localparam int GW           = $clog2(GAP_LEN + 1);

   rd_state_t            st;
   logic [HW-1:0]        hcnt;
   logic [GW-1:0]        gcnt;
   logic [ADDR_BITS-1:0] adr_sr;
   logic                 in_xfer;
   logic                 is_fall;

   assign in_xfer = (st == RD_XFER);
   assign hnext   = hcnt + HW'(1);
   assign is_fall = !hnext[0];
   assign done    = in_xfer && tick && (hnext == HW'(END_HALF));
   assign busy    = (st != RD_IDLE);
   assign sclk_en = in_xfer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RD_IDLE;
         hcnt   <= '0;
         gcnt   <= '0;
         adr_sr <= '0;
         cs_n   <= 1'b1;
         dq_o   <= 1'b0;
         dq_oe  <= 1'b0;
      end else begin
         unique case (st)
            RD_IDLE: begin
               if (req) begin
                  st     <= RD_XFER;
                  hcnt   <= '0;
                  adr_sr <= chan;
                  cs_n   <= 1'b0;
                  dq_o   <= 1'b1;   // start bit
                  dq_oe  <= 1'b1;
               end
            end
            RD_XFER: begin
               if (tick) begin
                  hcnt <= hnext;
                  if (hnext == HW'(END_HALF)) begin
                     st   <= RD_GAP;
                     gcnt <= '0;
                     cs_n <= 1'b1;
                  end else if (hnext == HW'(RELEASE_HALF)) begin
                     dq_oe <= 1'b0;
                     dq_o  <= 1'b0;
                  end else if (is_fall && (hnext < HW'(RELEASE_HALF))) begin
                     dq_o   <= adr_sr[ADDR_BITS-1];
                     adr_sr <= adr_sr << 1;
                  end
               end
            end
            RD_GAP: begin
               if (gcnt == GW'(GAP_LEN - 1)) st <= RD_IDLE;
               else                          gcnt <= gcnt + GW'(1);
            end
            default: st <= RD_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
   import adc_rd_pkg::*;
#(
   parameter int ADDR_BITS = 2,
   parameter int RES_BITS  = 8,
   parameter bit ECHO      = 1'b1,
   parameter int HW        = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rise_tk,
   input  logic [HW-1:0]       hnext,
   input  logic                din,
   input  logic                done,
   output logic [RES_BITS-1:0] rslt_data,
   output logic                rslt_err,
   output logic                rslt_valid
);
   localparam int MSB_LO = 2 * first_data_rise(ADDR_BITS) - 1;
   localparam int MSB_HI = 2 * last_msb_rise(ADDR_BITS, RES_BITS) - 1;

   logic [RES_BITS-1:0] msb_sr;
   logic                mismatch;
   logic                in_msb;

   assign in_msb = rise_tk && (hnext >= HW'(MSB_LO)) && (hnext <= HW'(MSB_HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      msb_sr <= '0;
      else if (in_msb) msb_sr <= {msb_sr[RES_BITS-2:0], din};
   end

   generate
      if (ECHO) begin : g_echo
         localparam int ECHO_LO = MSB_HI + 2;
         localparam int ECHO_HI = 2 * last_rise(ADDR_BITS, RES_BITS, ECHO) - 1;
         logic [RES_BITS-2:0] echo_sr;
         logic                in_echo;

         assign in_echo = rise_tk && (hnext >= HW'(ECHO_LO)) && (hnext <= HW'(ECHO_HI));

         // echo arrives bit 1 first; newest bit enters at the top
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       echo_sr <= '0;
            else if (in_echo) echo_sr <= {din, echo_sr[RES_BITS-2:1]};
         end

         assign mismatch = ({echo_sr, msb_sr[0]} != msb_sr);
      end else begin : g_noecho
         assign mismatch = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rslt_data  <= '0;
         rslt_err   <= 1'b0;
         rslt_valid <= 1'b0;
      end else begin
         rslt_valid <= done;
         if (done) begin
            rslt_data <= msb_sr;
            rslt_err  <= mismatch;
         end
      end
   end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
   import adc_rd_pkg::*;
#(
   parameter int DIV_HALF  = 4,
   parameter int ADDR_BITS = 2,
   parameter int RES_BITS  = 8,
   parameter bit ECHO      = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic [ADDR_BITS-1:0] chan,
   output logic                 busy,
   output logic                 rslt_valid,
   output logic [RES_BITS-1:0]  rslt_data,
   output logic                 rslt_err,
   output logic                 ser_cs_n,
   output logic                 ser_clk,
   output logic                 ser_dq_o,
   output logic                 ser_dq_oe,
   input  logic                 ser_dq_i
);
   localparam int HW = $clog2(2 * last_rise(ADDR_BITS, RES_BITS, ECHO) + 1);

   initial begin
      if (DIV_HALF < 1)  $error("DIV_HALF must be at least 1");
      if (ADDR_BITS < 1) $error("ADDR_BITS must be at least 1");
      if (RES_BITS < 4)  $error("RES_BITS must be at least 4");
   end

   logic          sclk_en;
   logic          rise_tk;
   logic          fall_tk;
   logic          done;
   logic [HW-1:0] hnext;

   adc_rd_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (sclk_en),
      .sclk    (ser_clk),
      .rise_tk (rise_tk),
      .fall_tk (fall_tk)
   );

   adc_rd_seq #(
      .DIV_HALF (DIV_HALF),
      .ADDR_BITS(ADDR_BITS),
      .RES_BITS (RES_BITS),
      .ECHO     (ECHO),
      .HW       (HW)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .chan    (chan),
      .tick    (rise_tk | fall_tk),
      .busy    (busy),
      .sclk_en (sclk_en),
      .cs_n    (ser_cs_n),
      .dq_o    (ser_dq_o),
      .dq_oe   (ser_dq_oe),
      .hnext   (hnext),
      .done    (done)
   );

   adc_rd_capture #(
      .ADDR_BITS(ADDR_BITS),
      .RES_BITS (RES_BITS),
      .ECHO     (ECHO),
      .HW       (HW)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_tk    (rise_tk),
      .hnext      (hnext),
      .din        (ser_dq_i),
      .done       (done),
      .rslt_data  (rslt_data),
      .rslt_err   (rslt_err),
      .rslt_valid (rslt_valid)
   );
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
   parameter int ADDR_BITS = 2,
   parameter int RES_BITS  = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req,
   input logic [ADDR_BITS-1:0] chan,
   input logic                 busy,
   input logic                 rslt_valid,
   input logic [RES_BITS-1:0]  rslt_data,
   input logic                 rslt_err,
   input logic                 ser_cs_n,
   input logic                 ser_clk,
   input logic                 ser_dq_o,
   input logic                 ser_dq_oe,
   input logic                 ser_dq_i
);
   AST_CLK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      ser_cs_n |-> !ser_clk);                                          // R2
   AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_cs_n |-> busy);                                             // R2
   AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      ser_cs_n |-> !ser_dq_oe);                                        // R4
   AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_dq_oe) |-> $fell(ser_clk));                            // R4
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rslt_valid |=> !rslt_valid);                                     // R7
   AST_VALID_WITH_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      rslt_valid |-> $rose(ser_cs_n));                                 // R7
   AST_START_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_cs_n) |-> $past(req && !busy));                        // R9
endmodule

bind adc_serial_reader adc_rd_chk #(.ADDR_BITS(ADDR_BITS), .RES_BITS(RES_BITS)) u_chk (.*);

// File: tb/tb_adc_serial_reader.sv
module tb_adc_serial_reader;
   localparam int DH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic [1:0] chan = 2'd0;
   logic       busy, rslt_valid, rslt_err;
   logic [7:0] rslt_data;
   logic       ser_cs_n, ser_clk, ser_dq_o, ser_dq_oe;
   logic       line;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   adc_serial_reader #(.DIV_HALF(DH)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .chan(chan),
      .busy(busy), .rslt_valid(rslt_valid), .rslt_data(rslt_data), .rslt_err(rslt_err),
      .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_dq_o(ser_dq_o),
      .ser_dq_oe(ser_dq_oe), .ser_dq_i(line)
   );

   // ---------------- behavioural converter ----------------
   logic [7:0] dev_tab [4];
   bit         corrupt = 1'b0;
   logic [4:0] d_r, d_f;
   logic [2:0] d_cmd, last_cmd;
   logic [4:0] last_rises;
   logic       d_oe, d_o;
   logic [7:0] d_word;
   int         cs_falls = 0;
   int         overlap = 0;

   assign line = ser_dq_oe ? ser_dq_o : (d_oe ? d_o : 1'b1);

   always @(posedge ser_clk or posedge ser_cs_n) begin
      if (ser_cs_n) begin
         last_cmd   <= d_cmd;
         last_rises <= d_r;
         d_r        <= '0;
         d_cmd      <= '0;
      end else begin
         d_r <= d_r + 5'd1;
         if (d_r < 5'd3) d_cmd <= {d_cmd[1:0], line};
      end
   end

   always @(negedge ser_clk or posedge ser_cs_n) begin
      if (ser_cs_n) begin
         d_f  <= '0;
         d_oe <= 1'b0;
         d_o  <= 1'b0;
      end else begin
         automatic int nf = int'(d_f) + 1;
         d_f <= d_f + 5'd1;
         if (nf == 3) d_word <= dev_tab[d_cmd[1:0]];
         if (nf >= 4 && nf <= 11) begin
            d_oe <= 1'b1;
            d_o  <= d_word[11-nf];
         end else if (nf >= 12 && nf <= 18) begin
            d_o <= d_word[nf-11] ^ (corrupt && nf == 14);
         end
      end
   end

   always @(negedge ser_cs_n) cs_falls++;
   always @(negedge clk) if (ser_dq_oe && d_oe) overlap++;

   // ---------------- checking helpers ----------------
   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one read; returns nothing, checks everything it measured
   task automatic do_read(input logic [1:0] ch, input logic [7:0] w, input bit bad,
                          input bit poke_busy);
      int n = 0, nv = -1, nb = -1, n_rise = -1, n_fall = -1, falls = 0, rel = -1;
      int hi_run = 0, lo_ok = 1;
      logic pc, po;
      logic [7:0] got_d;
      logic got_e = 1'b0;
      int falls0 = cs_falls;
      dev_tab[ch] = w;
      corrupt = bad;
      @(negedge clk);
      pc = ser_clk; po = ser_dq_oe;
      req = 1'b1; chan = ch;
      got_d = 8'h00;
      while (nb < 0 && n < 2000) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (n == 1) begin
            check(!ser_cs_n && busy, "R2 accept", {30'd0, ser_cs_n, busy}, 1);
            req = 1'b0;
            chan = ~ch;
         end
         if (poke_busy && (n == 20 || n == 90)) req = 1'b1;
         if (poke_busy && (n == 21 || n == 91)) req = 1'b0;
         if (!pc && ser_clk && n_rise < 0) n_rise = n;
         if (pc && !ser_clk) begin
            falls++;
            if (n_fall < 0) n_fall = n;
         end
         if (po && !ser_dq_oe) rel = falls;
         if (ser_clk) hi_run++;
         pc = ser_clk; po = ser_dq_oe;
         if (rslt_valid && nv < 0) begin
            nv = n; got_d = rslt_data; got_e = rslt_err;
         end
         if (nv > 0 && n == nv + 1)
            check(!rslt_valid, "R7 valid width", int'(rslt_valid), 0);
         if (nv > 0 && n == nv + 1 && poke_busy) req = 1'b1;
         if (nv > 0 && n == nv + 2 && poke_busy) req = 1'b0;
         if (!busy && nb < 0) nb = n;
      end
      if (rslt_valid) lo_ok = 0;
      check(n_rise == DH + 1, "R2 first rise", n_rise, DH + 1);
      check(n_fall == 2*DH + 1, "R2 high half", n_fall, 2*DH + 1);
      check(hi_run == 19*DH, "R2 duty", hi_run, 19*DH);
      check(last_cmd == {1'b1, ch}, "R3 command", int'(last_cmd), int'({1'b1, ch}));
      check(rel == 3, "R4 release edge", rel, 3);
      check(nv == 38*DH + 1, "R7 valid time", nv, 38*DH + 1);
      check(int'(last_rises) == 19, "R7 rise count", int'(last_rises), 19);
      check(got_d == w, "R5 data", int'(got_d), int'(w));
      check(got_e == bad, "R6 err flag", int'(got_e), int'(bad));
      check(nb == 40*DH + 1, "R8 busy end", nb, 40*DH + 1);
      check(cs_falls - falls0 == 1, "R9 single start", cs_falls - falls0, 1);
      check(lo_ok == 1, "R7 valid idle", lo_ok, 1);
      corrupt = 1'b0;
   endtask

   task automatic test_reset();
      @(negedge clk);
      check(ser_cs_n == 1'b1, "R1 cs_n", int'(ser_cs_n), 1);
      check(ser_clk == 1'b0, "R1 sclk", int'(ser_clk), 0);
      check(ser_dq_oe == 1'b0, "R1 oe", int'(ser_dq_oe), 0);
      check(busy == 1'b0, "R1 busy", int'(busy), 0);
      check(rslt_valid == 1'b0, "R1 valid", int'(rslt_valid), 0);
   endtask

   task automatic test_back_to_back();
      int hi = 0, f0;
      int n = 0;
      dev_tab[2] = 8'h3C;
      dev_tab[1] = 8'hC5;
      @(negedge clk);
      req = 1'b1; chan = 2'd2;
      while (!rslt_valid && n < 2000) begin @(negedge clk); n++; end
      check(rslt_data == 8'h3C, "R5 first of pair", int'(rslt_data), 8'h3C);
      chan = 2'd1;
      f0 = cs_falls;
      while (ser_cs_n && hi < 2000) begin hi++; @(negedge clk); end
      req = 1'b0;
      check(hi == 2*DH + 1, "R8 cs high gap", hi, 2*DH + 1);
      check(cs_falls - f0 == 1, "R8 reaccept", cs_falls - f0, 1);
      n = 0;
      while (!rslt_valid && n < 2000) begin @(negedge clk); n++; end
      check(rslt_data == 8'hC5 && !rslt_err, "R5 second of pair", int'(rslt_data), 8'hC5);
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      do_read(2'd0, 8'hA5, 1'b0, 1'b0);
      do_read(2'd3, 8'h01, 1'b0, 1'b0);
      do_read(2'd1, 8'h80, 1'b0, 1'b0);
      do_read(2'd2, 8'h00, 1'b0, 1'b0);
      do_read(2'd3, 8'hFF, 1'b0, 1'b0);
      do_read(2'd1, 8'h6B, 1'b1, 1'b0);   // R6 corrupted echo
      do_read(2'd2, 8'h5A, 1'b0, 1'b1);   // R9 requests while busy
      test_back_to_back();
      check(overlap == 0, "R4 no overlap", overlap, 0);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule